// File: doc/BRIEF.md
# Type B frame transmitter

This block turns a stream of bytes into the bit-level envelope of a Type B proximity-card frame. It runs on the carrier clock and counts every interval in carrier cycles. A frame has three parts. It opens with an optional start delimiter, which is a long low period followed by a short high period. The characters follow. Each character is a low start bit, eight data bits sent least significant bit first, and a high stop bit, and it may be followed by extra high guard periods. The frame closes with an optional end delimiter, which is a long low period. The bit period (etu) is given as a carrier-cycle count, typically 128.

Bytes arrive on a valid/ready stream. A last-byte flag marks the final character of the frame. The delimiter lengths can be set to a short form, a long form, or a carrier-trimmed form. Each delimiter can be left out on its own, and a 2-bit code sets the guard time. The whole configuration and the etu are sampled when the first byte of a frame is taken, so changing them during a frame has no effect. The output is one envelope bit, high at idle, together with a busy flag. A separate flag reports the one invalid delimiter-setting combination.

Top module: `typeb_frame_tx`

## Requirements
- R1: After reset, and between frames, `mod_out` is 1, `busy` is 0 and `in_ready` is 1.
- R2: Each character is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Every bit lasts `etu_cycles` carrier cycles.
- R3: The guard code `cfg_guard` (00, 01, 10, 11) adds 0, 1, 2 or 3 high etu after every stop bit, including the stop bit of the last character.
- R4: With `cfg_wide`=0 and `cfg_adjust`=0, the start delimiter is 10 etu low then 2 etu high, and the end delimiter is 10 etu low.
- R5: With `cfg_wide`=1 and `cfg_adjust`=0, the start delimiter is 11 etu low then 3 etu high, and the end delimiter is 11 etu low.
- R6: With `cfg_wide`=1 and `cfg_adjust`=1, the start delimiter is 11·etu−8 cycles low then 2·etu+8 cycles high, and the end delimiter is 11·etu−8 cycles low.
- R7: With `cfg_wide`=0 and `cfg_adjust`=1, the R4 lengths are used. `cfg_err` is 1 one cycle after the inputs show this combination and 0 one cycle after they show any other combination.
- R8: With `cfg_no_sof`=1, the frame begins directly with the start bit of the first character.
- R9: With `cfg_no_eof`=1, no end delimiter is sent, and `busy` falls when the last guard time (or the last stop bit) ends.
- R10: `busy` and the first low of the frame appear one cycle after the first byte is accepted. `busy` stays high for exactly the total frame length when bytes arrive on time. `in_ready` is 0 inside a frame except in the last cycle of each character's guard time (of its stop bit when the guard code is 00), so a byte waiting then starts with no gap.
- R11: The configuration inputs and `etu_cycles` are sampled when the first byte of a frame is accepted. Changes during the frame do not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte present |
| in_last | input | 1 | Byte is the final character of the frame |
| in_ready | output | 1 | Byte taken at this edge when valid |
| cfg_no_sof | input | 1 | Leave out the start delimiter |
| cfg_no_eof | input | 1 | Leave out the end delimiter |
| cfg_wide | input | 1 | Delimiter length select |
| cfg_adjust | input | 1 | Carrier-cycle trim of the delimiters |
| cfg_guard | input | 2 | Extra guard etu after each stop bit |
| etu_cycles | input | ETU_W | Bit period in carrier cycles (at least 16) |
| mod_out | output | 1 | Modulation envelope, 1 at idle |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Invalid delimiter-setting combination present |

## Verification
Two events fall in the same cycle: a character's guard time (or its stop bit) ends, and the next byte is accepted. The bench keeps the next byte valid before the current character ends, so the hand-over always happens on that final cycle. The scoreboard judges the result by comparing every merged high and low run length on `mod_out` against the values computed from the requirements; one extra or missing cycle at the hand-over changes a run. A second collision is provoked by changing every configuration input right after a frame starts; the run lengths must still match the configuration that was sampled.

// File: rtl/typeb_tx_pkg.sv
package typeb_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF_LO,
    ST_SOF_HI,
    ST_CHAR,
    ST_GUARD,
    ST_WAITB,
    ST_EOF_LO
  } tx_state_e;

  localparam int CHAR_BITS   = 10;
  localparam int STOP_IDX    = CHAR_BITS - 1;
  localparam int LO_SHORT    = 10;
  localparam int LO_LONG     = 11;
  localparam int HI_SHORT    = 2;
  localparam int HI_LONG     = 3;
  localparam int TRIM_CYCLES = 8;

endpackage

// File: rtl/typeb_delim_calc.sv
module typeb_delim_calc #(
  parameter int ETU_W = 10,
  parameter int LEN_W = ETU_W + 4
) (
  input  logic [ETU_W-1:0] etu,
  input  logic             wide,
  input  logic             adjust,
  input  logic [1:0]       guard,
  output logic [LEN_W-1:0] sof_lo_len,
  output logic [LEN_W-1:0] sof_hi_len,
  output logic [LEN_W-1:0] eof_lo_len,
  output logic [LEN_W-1:0] guard_len
);
  import typeb_tx_pkg::*;

  logic [LEN_W-1:0] etu_l;
  logic [LEN_W-1:0] lo_short, lo_long, hi_short, hi_long;
  logic [LEN_W-1:0] part [2];

  assign etu_l    = LEN_W'(etu);
  assign lo_short = etu_l * LEN_W'(LO_SHORT);
  assign lo_long  = etu_l * LEN_W'(LO_LONG);
  assign hi_short = etu_l * LEN_W'(HI_SHORT);
  assign hi_long  = etu_l * LEN_W'(HI_LONG);

  // long form: wide only; trimmed form: wide and adjust; else the short form
  always_comb begin
    if (wide && adjust) begin
      sof_lo_len = lo_long - LEN_W'(TRIM_CYCLES);
      sof_hi_len = hi_short + LEN_W'(TRIM_CYCLES);
      eof_lo_len = lo_long - LEN_W'(TRIM_CYCLES);
    end else if (wide) begin
      sof_lo_len = lo_long;
      sof_hi_len = hi_long;
      eof_lo_len = lo_long;
    end else begin
      sof_lo_len = lo_short;
      sof_hi_len = hi_short;
      eof_lo_len = lo_short;
    end
  end

  // guard length = code * etu, built from shifted partial terms
  for (genvar i = 0; i < 2; i++) begin : g_guard
    assign part[i] = guard[i] ? (etu_l << i) : '0;
  end
  assign guard_len = part[0] + part[1];

endmodule

// File: rtl/typeb_cycle_timer.sv
module typeb_cycle_timer #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  output logic             tick
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val - LEN_W'(1);
    else if (cnt != '0)
      cnt <= cnt - LEN_W'(1);
  end

  assign tick = (cnt == '0);

endmodule

// File: rtl/typeb_frame_ctrl.sv
module typeb_frame_ctrl #(
  parameter int ETU_W = 10,
  parameter int LEN_W = ETU_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             cfg_no_sof,
  input  logic             cfg_no_eof,
  input  logic [ETU_W-1:0] etu,
  input  logic [LEN_W-1:0] sof_lo_len,
  input  logic [LEN_W-1:0] sof_hi_len,
  input  logic [LEN_W-1:0] eof_lo_len,
  input  logic [LEN_W-1:0] guard_len,
  input  logic             tick,
  output logic             ld,
  output logic [LEN_W-1:0] ld_val,
  output logic             line_level,
  output logic             active
);
  import typeb_tx_pkg::*;

  tx_state_e        st, st_n;
  logic [3:0]       bit_q;
  logic [7:0]       data_q;
  logic             last_q;
  logic [LEN_W-1:0] etu_q, sof_hi_q, eof_q, guard_q;
  logic             no_eof_q;
  logic             char_done, accept, start;
  logic [2:0]       didx;

  assign char_done = (st == ST_CHAR && bit_q == 4'(STOP_IDX) && tick && guard_q == '0)
                   || (st == ST_GUARD && tick);
  assign in_ready  = (st == ST_IDLE) || (st == ST_WAITB) || (char_done && !last_q);
  assign accept    = in_valid && in_ready;
  assign start     = accept && (st == ST_IDLE);

  always_comb begin
    st_n   = st;
    ld     = 1'b0;
    ld_val = etu_q;
    if (char_done) begin
      if (last_q) begin
        if (no_eof_q) begin
          st_n = ST_IDLE;
        end else begin
          st_n   = ST_EOF_LO;
          ld     = 1'b1;
          ld_val = eof_q;
        end
      end else if (accept) begin
        st_n = ST_CHAR;
        ld   = 1'b1;
      end else begin
        st_n = ST_WAITB;
      end
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st_n   = cfg_no_sof ? ST_CHAR : ST_SOF_LO;
          ld     = 1'b1;
          ld_val = cfg_no_sof ? LEN_W'(etu) : sof_lo_len;
        end
        ST_SOF_LO: if (tick) begin
          st_n   = ST_SOF_HI;
          ld     = 1'b1;
          ld_val = sof_hi_q;
        end
        ST_SOF_HI: if (tick) begin
          st_n = ST_CHAR;
          ld   = 1'b1;
        end
        ST_CHAR: if (tick) begin
          ld = 1'b1;
          if (bit_q == 4'(STOP_IDX)) begin
            st_n   = ST_GUARD;
            ld_val = guard_q;
          end
        end
        ST_WAITB: if (accept) begin
          st_n = ST_CHAR;
          ld   = 1'b1;
        end
        ST_EOF_LO: if (tick) st_n = ST_IDLE;
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bit_q    <= '0;
      data_q   <= '0;
      last_q   <= 1'b0;
      etu_q    <= '0;
      sof_hi_q <= '0;
      eof_q    <= '0;
      guard_q  <= '0;
      no_eof_q <= 1'b0;
    end else begin
      st <= st_n;
      if (st_n == ST_CHAR) begin
        if (st != ST_CHAR || char_done)
          bit_q <= '0;
        else if (tick)
          bit_q <= bit_q + 4'd1;
      end
      if (accept) begin
        data_q <= in_data;
        last_q <= in_last;
      end
      if (start) begin
        etu_q    <= LEN_W'(etu);
        sof_hi_q <= sof_hi_len;
        eof_q    <= eof_lo_len;
        guard_q  <= guard_len;
        no_eof_q <= cfg_no_eof;
      end
    end
  end

  assign didx = 3'(bit_q - 4'd1);

  always_comb begin
    case (st)
      ST_SOF_LO, ST_EOF_LO: line_level = 1'b0;
      ST_CHAR: begin
        if (bit_q == 4'd0)
          line_level = 1'b0;
        else if (bit_q == 4'(STOP_IDX))
          line_level = 1'b1;
        else
          line_level = data_q[didx];
      end
      default: line_level = 1'b1;
    endcase
  end

  assign active = (st != ST_IDLE);

endmodule

// File: rtl/typeb_frame_tx.sv
module typeb_frame_tx #(
  parameter int ETU_W = 10,
  parameter int LEN_W = ETU_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             cfg_no_sof,
  input  logic             cfg_no_eof,
  input  logic             cfg_wide,
  input  logic             cfg_adjust,
  input  logic [1:0]       cfg_guard,
  input  logic [ETU_W-1:0] etu_cycles,
  output logic             mod_out,
  output logic             busy,
  output logic             cfg_err
);
  logic [LEN_W-1:0] sof_lo_len, sof_hi_len, eof_lo_len, guard_len;
  logic             tick, ld, line_level, active;
  logic [LEN_W-1:0] ld_val;

  typeb_delim_calc #(.ETU_W(ETU_W), .LEN_W(LEN_W)) calc_i (
    .etu        (etu_cycles),
    .wide       (cfg_wide),
    .adjust     (cfg_adjust),
    .guard      (cfg_guard),
    .sof_lo_len (sof_lo_len),
    .sof_hi_len (sof_hi_len),
    .eof_lo_len (eof_lo_len),
    .guard_len  (guard_len)
  );

  typeb_cycle_timer #(.LEN_W(LEN_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .tick     (tick)
  );

  typeb_frame_ctrl #(.ETU_W(ETU_W), .LEN_W(LEN_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .cfg_no_sof (cfg_no_sof),
    .cfg_no_eof (cfg_no_eof),
    .etu        (etu_cycles),
    .sof_lo_len (sof_lo_len),
    .sof_hi_len (sof_hi_len),
    .eof_lo_len (eof_lo_len),
    .guard_len  (guard_len),
    .tick       (tick),
    .ld         (ld),
    .ld_val     (ld_val),
    .line_level (line_level),
    .active     (active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_out <= 1'b1;
      busy    <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      mod_out <= line_level;
      busy    <= active;
      cfg_err <= !cfg_wide && cfg_adjust;
    end
  end

endmodule

// File: rtl/typeb_frame_tx_chk.sv
module typeb_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_wide,
  input logic cfg_adjust,
  input logic mod_out,
  input logic busy,
  input logic cfg_err
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mod_out);

  a_r10_frame_starts_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !mod_out);

  a_r10_frame_ends_high: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> mod_out);

  a_r10_accept_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !busy) |-> ##2 busy);

  a_r7_err_set: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wide && cfg_adjust) |=> cfg_err);

  a_r7_err_clear: assert property (@(posedge clk) disable iff (rst)
    !(!cfg_wide && cfg_adjust) |=> !cfg_err);
endmodule

bind typeb_frame_tx typeb_frame_tx_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cfg_wide   (cfg_wide),
  .cfg_adjust (cfg_adjust),
  .mod_out    (mod_out),
  .busy       (busy),
  .cfg_err    (cfg_err)
);

// File: tb/typeb_frame_tx_tb_top.sv
module typeb_frame_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ETU_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic cfg_no_sof = 1'b0, cfg_no_eof = 1'b0, cfg_wide = 1'b0, cfg_adjust = 1'b0;
  logic [1:0] cfg_guard = '0;
  logic [ETU_W-1:0] etu_cycles = 10'd16;
  logic mod_out, busy, cfg_err;

  int checks = 0, bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  bit exp_lvl_q[$];
  int exp_len_q[$];
  int exp_busy_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  typeb_frame_tx #(.ETU_W(ETU_W)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .cfg_no_sof(cfg_no_sof),
    .cfg_no_eof(cfg_no_eof), .cfg_wide(cfg_wide), .cfg_adjust(cfg_adjust),
    .cfg_guard(cfg_guard), .etu_cycles(etu_cycles), .mod_out(mod_out),
    .busy(busy), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic add_run(input bit first, input bit l, input int c);
    if (!first && exp_lvl_q.size() > 0 && exp_lvl_q[exp_lvl_q.size()-1] == l)
      exp_len_q[exp_len_q.size()-1] += c;
    else begin
      exp_lvl_q.push_back(l);
      exp_len_q.push_back(c);
    end
  endtask

  // scoreboard monitor: measures merged runs of mod_out while busy
  bit prev_busy = 0;
  bit cur_lvl = 1;
  int cur_len = 0, bcnt = 0;

  task automatic close_run();
    bit l;
    int n;
    if (exp_len_q.size() == 0) begin
      chk(0, cur_tag, cur_len, -1);
    end else begin
      l = exp_lvl_q.pop_front();
      n = exp_len_q.pop_front();
      chk(l == cur_lvl, cur_tag, int'(cur_lvl), int'(l));
      chk(n == cur_len, cur_tag, cur_len, n);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !prev_busy) begin
        cur_lvl = mod_out; cur_len = 1; bcnt = 1;
      end else if (busy) begin
        bcnt++;
        if (mod_out == cur_lvl) cur_len++;
        else begin close_run(); cur_lvl = mod_out; cur_len = 1; end
      end else if (prev_busy) begin
        if (cur_lvl == 1'b0) close_run();
        if (exp_busy_q.size() == 0) chk(0, cur_tag, bcnt, -1);
        else begin
          int eb;
          eb = exp_busy_q.pop_front();
          chk(bcnt == eb, cur_tag, bcnt, eb);
        end
        chk(exp_len_q.size() == 0, cur_tag, exp_len_q.size(), 0);
      end
      prev_busy = busy;
    end
  end

  // driver: computes expected runs, then feeds the bytes
  task automatic run_frame(input string tag, input logic [7:0] b0, b1, b2, input int n,
                           input bit nosof, noeof, wide, adj, input int g, input int etu,
                           input bit scramble, input bit chk_ready);
    int lo, hi, eo, total;
    bit first;
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    cur_tag = tag;
    if (wide && adj) begin lo = 11*etu - 8; hi = 2*etu + 8; eo = 11*etu - 8; end
    else if (wide)   begin lo = 11*etu;     hi = 3*etu;     eo = 11*etu;     end
    else             begin lo = 10*etu;     hi = 2*etu;     eo = 10*etu;     end
    first = 1;
    total = 0;
    if (!nosof) begin
      add_run(first, 1'b0, lo); first = 0;
      add_run(first, 1'b1, hi);
      total += lo + hi;
    end
    for (int k = 0; k < n; k++) begin
      add_run(first, 1'b0, etu); first = 0;
      for (int j = 0; j < 8; j++) add_run(first, bytes[k][j], etu);
      add_run(first, 1'b1, etu * (1 + g));
      total += etu * (10 + g);
    end
    if (!noeof) begin
      add_run(first, 1'b0, eo);
      total += eo;
    end
    if (exp_lvl_q[exp_lvl_q.size()-1] == 1'b1) begin
      void'(exp_lvl_q.pop_back());
      void'(exp_len_q.pop_back());
    end
    exp_busy_q.push_back(total);

    cfg_no_sof = nosof; cfg_no_eof = noeof; cfg_wide = wide; cfg_adjust = adj;
    cfg_guard = 2'(g); etu_cycles = ETU_W'(etu);
    for (int k = 0; k < n; k++) begin
      in_data = bytes[k]; in_last = (k == n-1); in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (k == 0 && scramble) begin
        cfg_no_sof = ~nosof; cfg_no_eof = ~noeof; cfg_wide = ~wide;
        cfg_adjust = ~adj; cfg_guard = ~2'(g); etu_cycles = ETU_W'(etu + 5);
      end
      if (k == 0 && chk_ready) begin
        @(negedge clk);
        chk(busy == 1'b1, "R10", int'(busy), 1);
        chk(in_ready == 1'b0, "R10", int'(in_ready), 0);
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mod_out == 1'b1, "R1", int'(mod_out), 1);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    chk(cfg_err == 1'b0, "R7", int'(cfg_err), 0);

    // R2 and R4: short delimiters, no guard
    run_frame("R4", 8'hA5, 8'h3C, 8'h00, 2, 0, 0, 0, 0, 0, 16, 0, 0);
    // R5: long delimiters, one guard etu
    run_frame("R5", 8'h00, 8'hFF, 8'h81, 3, 0, 0, 1, 0, 1, 20, 0, 0);
    // R6: trimmed delimiters, two guard etu
    run_frame("R6", 8'h5A, 8'h00, 8'h00, 1, 0, 0, 1, 1, 2, 16, 0, 0);
    // R7: invalid combination
    cfg_wide = 1'b0; cfg_adjust = 1'b1;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R7", int'(cfg_err), 1);
    run_frame("R7", 8'hC3, 8'h01, 8'h00, 2, 0, 0, 0, 1, 3, 16, 0, 0);
    cfg_adjust = 1'b0;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R7", int'(cfg_err), 0);
    // R8: no start delimiter
    run_frame("R8", 8'h7E, 8'h80, 8'h00, 2, 1, 0, 0, 0, 1, 16, 0, 0);
    // R9: no end delimiter
    run_frame("R9", 8'h11, 8'h00, 8'h00, 1, 0, 1, 1, 0, 2, 18, 0, 0);
    run_frame("R9", 8'hE7, 8'h42, 8'h00, 2, 1, 1, 0, 0, 0, 16, 0, 0);
    // R3: maximal guard between all-ones bytes
    run_frame("R3", 8'hFF, 8'hFF, 8'h0F, 3, 0, 0, 0, 0, 3, 16, 0, 0);
    // R2 and R10: single byte, ready low inside the character
    run_frame("R2", 8'h01, 8'h00, 8'h00, 1, 0, 0, 0, 0, 0, 16, 0, 1);
    // R11: inputs changed right after the frame starts
    run_frame("R11", 8'h96, 8'h69, 8'h00, 2, 0, 0, 1, 0, 1, 16, 1, 0);
    // R1 idle again between frames
    chk(mod_out == 1'b1, "R1", int'(mod_out), 1);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule